// File: doc/BRIEF.md
# Dual-Channel Command Byte Interpreter

This block sits behind the serial port of a two-channel line-interface controller and turns the incoming byte stream into control actions. Each byte arrives with a one-cycle valid strobe. The first byte of a command holds three fields: an operation flag, a 3-bit command code and a 3-bit channel address. The block then decides whether the command is complete or whether one more byte follows.

When the operation flag is set, the command code selects one of these actions:
- a soft reset of the whole device;
- a soft reset of one channel;
- a resynchronisation request for the PCM port;
- the start of a status transfer or of a coefficient transfer, each of which takes a sub-address byte.

When the flag is clear, the command code is written straight into the addressed channel's 3-bit operating-mode register.

Every action appears as a registered single-cycle pulse in the cycle after the completing byte is accepted. Transfers are reported as a descriptor with a valid pulse. The data phase of a transfer is handled by a neighbouring block. A frame-abort input discards a command that is only half received.

Top module: `dual_chan_cmd_parser`

## Requirements
- R1: A first byte is decoded as: bit 7 is the operation flag, bits 6:4 are the command code, bits 2:0 are the channel address, and bit 3 is ignored. With the flag at 0, a valid channel address and any code other than 011, the code is written to that channel's mode register, visible in the cycle after acceptance. With the flag at 0 and code 011, only err_p is pulsed.
- R2: After synchronous reset, both mode registers read 000, every pulse output is 0, and the next accepted byte is treated as a first byte.
- R3: Flag 1 with code 000 pulses glob_rst_p for one cycle and clears both mode registers to 000 in the same cycle, whatever the address field holds.
- R4: Flag 1 with code 001 and a valid address pulses bit `address` of chan_rst_p and clears that channel's mode register to 000. The other channel is left unchanged.
- R5: Flag 1 with code 010 pulses resync_p only if pcm_strap was 1 when the byte was accepted. Otherwise it has no visible effect, and no error is flagged.
- R6: Flag 1 with code 100 (status) or 101 (coefficient) and a valid address expects a second byte and produces no action on the first byte. On the second byte, txn_vld pulses together with txn_coef (0 status, 1 coefficient), txn_chan (the address) and txn_sub (the whole second byte).
- R7: Flag 1 with code 011 is a one-byte command that pulses err_p only. No mode register changes.
- R8: Flag 1 with code 110 or 111 pulses err_p on the first byte. The byte that follows is consumed with no action.
- R9: Address codes 000 and 001 select channels A and B. Any other address on a mode write, a channel reset or a transfer command pulses err_p and causes no state change. A transfer command with a bad address still consumes its second byte with no action.
- R10: frame_abort at 1 discards any partial command and any byte offered in the same cycle. The next accepted byte is treated as a first byte.
- R11: Every action output is high for exactly one cycle per completing byte. No action output rises in a cycle after which no byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_abort | input | 1 | Drop any partial command |
| byte_vld | input | 1 | byte_dat holds a byte this cycle |
| byte_dat | input | 8 | Incoming command byte |
| pcm_strap | input | 1 | PCM-mode strap; gates resynchronisation |
| glob_rst_p | output | 1 | Device soft-reset pulse |
| chan_rst_p | output | NCH | Per-channel soft-reset pulses |
| resync_p | output | 1 | PCM resynchronisation pulse |
| err_p | output | 1 | Reserved command or address pulse |
| chan_mode | output | 3*NCH | Mode registers, channel i at bits 3i+2:3i |
| txn_vld | output | 1 | Transfer descriptor valid pulse |
| txn_coef | output | 1 | 1 coefficient transfer, 0 status transfer |
| txn_chan | output | max(1,clog2(NCH)) | Transfer channel |
| txn_sub | output | 8 | Sub-address byte |

## Verification
The bench builds the block with its default of two channels. This leaves six of the eight address codes reserved, so the error path is reached by a large share of the byte space. With this configuration, every one of the 256 first-byte values can be swept under both strap settings. Each two-byte command gets a follow-up byte that would itself write a mode if it were wrongly taken, so any swallowed byte that leaks through shows up as a mode change. Abort is exercised both between the two bytes and in the same cycle as a byte.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 3;
  localparam int ADR_W  = 3;
  localparam int MODE_W = 3;

  localparam logic [CMD_W-1:0] C_GRST  = 3'b000;
  localparam logic [CMD_W-1:0] C_CRST  = 3'b001;
  localparam logic [CMD_W-1:0] C_RSYNC = 3'b010;
  localparam logic [CMD_W-1:0] C_RSVD  = 3'b011;
  localparam logic [CMD_W-1:0] C_STAT  = 3'b100;
  localparam logic [CMD_W-1:0] C_COEF  = 3'b101;

  typedef enum logic [2:0] {
    K_MODE,   // write operating mode
    K_GRST,   // device soft reset
    K_CRST,   // channel soft reset
    K_RSYNC,  // PCM resynchronisation
    K_XFER,   // two-byte transfer start
    K_BAD1,   // rejected, single byte
    K_BAD2    // rejected, swallow next byte
  } kind_t;
endpackage

// File: rtl/cmdp_decode.sv
module cmdp_decode
  import cmdp_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              op,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADR_W-1:0]  adr,
  output kind_t             kind,
  output logic              adr_ok
);
  localparam logic [ADR_W-1:0] NCH_A = ADR_W'(NCH);

  always_comb begin
    adr_ok = (adr < NCH_A);
    kind   = K_BAD1;
    if (!op) begin
      kind = (adr_ok && cmd != C_RSVD) ? K_MODE : K_BAD1;
    end else begin
      unique case (cmd)
        C_GRST:         kind = K_GRST;
        C_CRST:         kind = adr_ok ? K_CRST : K_BAD1;
        C_RSYNC:        kind = K_RSYNC;
        C_RSVD:         kind = K_BAD1;
        C_STAT, C_COEF: kind = adr_ok ? K_XFER : K_BAD2;
        default:        kind = K_BAD2;
      endcase
    end
  end
endmodule

// File: rtl/cmdp_seq.sv
module cmdp_seq
  import cmdp_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_abort,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic              pcm_strap,
  input  kind_t             kind,
  input  logic [CH_W-1:0]   chan,
  output logic              act_grst,
  output logic [NCH-1:0]    act_crst,
  output logic              act_mwr,
  output logic              glob_rst_p,
  output logic [NCH-1:0]    chan_rst_p,
  output logic              resync_p,
  output logic              err_p,
  output logic              txn_vld,
  output logic              txn_coef,
  output logic [CH_W-1:0]   txn_chan,
  output logic [BYTE_W-1:0] txn_sub
);
  logic            wait2, drop2, pend_coef;
  logic [CH_W-1:0] pend_chan;
  logic            take, first, second;

  assign take   = byte_vld && !frame_abort;
  assign first  = take && !wait2;
  assign second = take && wait2;

  always_comb begin
    act_grst = first && (kind == K_GRST);
    act_mwr  = first && (kind == K_MODE);
    for (int i = 0; i < NCH; i++)
      act_crst[i] = first && (kind == K_CRST) && (chan == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait2      <= 1'b0;
      drop2      <= 1'b0;
      pend_coef  <= 1'b0;
      pend_chan  <= '0;
      glob_rst_p <= 1'b0;
      chan_rst_p <= '0;
      resync_p   <= 1'b0;
      err_p      <= 1'b0;
      txn_vld    <= 1'b0;
      txn_coef   <= 1'b0;
      txn_chan   <= '0;
      txn_sub    <= '0;
    end else begin
      glob_rst_p <= act_grst;
      chan_rst_p <= act_crst;
      resync_p   <= first && (kind == K_RSYNC) && pcm_strap;
      err_p      <= first && (kind == K_BAD1 || kind == K_BAD2);
      txn_vld    <= second && !drop2;
      if (second && !drop2) begin
        txn_coef <= pend_coef;
        txn_chan <= pend_chan;
        txn_sub  <= byte_dat;
      end
      if (frame_abort) begin
        wait2 <= 1'b0;
      end else if (first) begin
        wait2     <= (kind == K_XFER) || (kind == K_BAD2);
        drop2     <= (kind == K_BAD2);
        pend_coef <= (byte_dat[6:4] == C_COEF);
        pend_chan <= chan;
      end else if (second) begin
        wait2 <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdp_mode_bank.sv
module cmdp_mode_bank
  import cmdp_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  grst,
  input  logic [NCH-1:0]        crst,
  input  logic                  mwr,
  input  logic [CH_W-1:0]       mwr_chan,
  input  logic [MODE_W-1:0]     mwr_val,
  output logic [NCH*MODE_W-1:0] modes
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [MODE_W-1:0] m_q;
    always_ff @(posedge clk) begin
      if (rst || grst || crst[i])
        m_q <= '0;
      else if (mwr && mwr_chan == CH_W'(i))
        m_q <= mwr_val;
    end
    assign modes[i*MODE_W +: MODE_W] = m_q;
  end
endmodule

// File: rtl/dual_chan_cmd_parser.sv
module dual_chan_cmd_parser
  import cmdp_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                frame_abort,
  input  logic                                byte_vld,
  input  logic [7:0]                          byte_dat,
  input  logic                                pcm_strap,
  output logic                                glob_rst_p,
  output logic [NCH-1:0]                      chan_rst_p,
  output logic                                resync_p,
  output logic                                err_p,
  output logic [NCH*3-1:0]                    chan_mode,
  output logic                                txn_vld,
  output logic                                txn_coef,
  output logic [((NCH>1)?$clog2(NCH):1)-1:0]  txn_chan,
  output logic [7:0]                          txn_sub
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  kind_t           kind;
  logic            adr_ok;
  logic            act_grst, act_mwr;
  logic [NCH-1:0]  act_crst;
  logic [CH_W-1:0] chan;

  assign chan = byte_dat[CH_W-1:0];

  cmdp_decode #(.NCH(NCH)) u_dec (
    .op     (byte_dat[7]),
    .cmd    (byte_dat[6:4]),
    .adr    (byte_dat[2:0]),
    .kind   (kind),
    .adr_ok (adr_ok)
  );

  cmdp_seq #(.NCH(NCH)) u_seq (
    .clk, .rst, .frame_abort, .byte_vld, .byte_dat, .pcm_strap,
    .kind, .chan,
    .act_grst, .act_crst, .act_mwr,
    .glob_rst_p, .chan_rst_p, .resync_p, .err_p,
    .txn_vld, .txn_coef, .txn_chan, .txn_sub
  );

  cmdp_mode_bank #(.NCH(NCH)) u_modes (
    .clk, .rst,
    .grst     (act_grst),
    .crst     (act_crst),
    .mwr      (act_mwr && adr_ok),
    .mwr_chan (chan),
    .mwr_val  (byte_dat[6:4]),
    .modes    (chan_mode)
  );
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_abort,
  input logic             byte_vld,
  input logic             pcm_strap,
  input logic             glob_rst_p,
  input logic [NCH-1:0]   chan_rst_p,
  input logic             resync_p,
  input logic             err_p,
  input logic [NCH*3-1:0] chan_mode,
  input logic             txn_vld
);
  a_r3_grst_clears_modes: assert property (@(posedge clk) disable iff (rst)
    glob_rst_p |-> chan_mode == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r4_crst_clears_mode: assert property (@(posedge clk) disable iff (rst)
      chan_rst_p[i] |-> chan_mode[i*3 +: 3] == 3'b000);
  end

  a_r5_resync_needs_strap: assert property (@(posedge clk) disable iff (rst)
    resync_p |-> $past(pcm_strap));

  a_r7_err_keeps_modes: assert property (@(posedge clk) disable iff (rst)
    err_p |-> $stable(chan_mode));

  a_r6_txn_after_byte: assert property (@(posedge clk) disable iff (rst)
    txn_vld |-> $past(byte_vld));

  a_r10_abort_no_action: assert property (@(posedge clk) disable iff (rst)
    $past(frame_abort) |-> !(glob_rst_p || (|chan_rst_p) || resync_p || err_p || txn_vld));

  a_r11_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({glob_rst_p, |chan_rst_p, resync_p, err_p, txn_vld}) && $onehot0(chan_rst_p));

  a_r11_no_byte_no_action: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_vld) |-> !(glob_rst_p || (|chan_rst_p) || resync_p || err_p || txn_vld));
endmodule

bind dual_chan_cmd_parser cmdp_checker #(.NCH(NCH)) u_cmdp_checker (
  .clk, .rst, .frame_abort, .byte_vld, .pcm_strap,
  .glob_rst_p, .chan_rst_p, .resync_p, .err_p, .chan_mode, .txn_vld
);

// File: tb/dual_chan_cmd_parser_test.sv
module dual_chan_cmd_parser_test;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;

  logic       clk = 1'b0, rst = 1'b1, frame_abort = 1'b0, byte_vld = 1'b0, pcm_strap = 1'b0;
  logic [7:0] byte_dat = '0;
  logic       glob_rst_p, resync_p, err_p, txn_vld, txn_coef;
  logic [NCH-1:0]   chan_rst_p;
  logic [NCH*3-1:0] chan_mode;
  logic [0:0]       txn_chan;
  logic [7:0]       txn_sub;

  dual_chan_cmd_parser #(.NCH(NCH)) uut (
    .clk, .rst, .frame_abort, .byte_vld, .byte_dat, .pcm_strap,
    .glob_rst_p, .chan_rst_p, .resync_p, .err_p, .chan_mode,
    .txn_vld, .txn_coef, .txn_chan, .txn_sub
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int em [2];
  bit ew = 0, edrop = 0, ecoef = 0;
  int echan = 0;
  string etag = "R6";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, int eg, int ecr, int ers, int eer, int etx);
    chk(tag, int'(glob_rst_p), eg);
    chk(tag, int'(chan_rst_p), ecr);
    chk(tag, int'(resync_p), ers);
    chk(tag, int'(err_p), eer);
    chk(tag, int'(txn_vld), etx);
    chk(tag, int'(chan_mode[2:0]), em[0]);
    chk(tag, int'(chan_mode[5:3]), em[1]);
  endtask

  task automatic clock_byte(logic [7:0] b, logic ab);
    byte_vld = 1'b1; byte_dat = b; frame_abort = ab;
    @(posedge clk); @(negedge clk);
    byte_vld = 1'b0; frame_abort = 1'b0;
  endtask

  task automatic feed(logic [7:0] b);
    int eg = 0, ecr = 0, ers = 0, eer = 0, etx = 0;
    string tag;
    logic op; logic [2:0] c, a; bit aok;
    if (ew) begin
      ew = 0;
      tag = etag;
      if (!edrop) etx = 1;
    end else begin
      op = b[7]; c = b[6:4]; a = b[2:0]; aok = (a < 2);
      if (!op) begin
        if (aok && c != 3) begin em[a] = int'(c); tag = "R1"; end
        else begin eer = 1; tag = aok ? "R1" : "R9"; end
      end else begin
        case (c)
          3'd0: begin eg = 1; em[0] = 0; em[1] = 0; tag = "R3"; end
          3'd1: if (aok) begin ecr = 1 << a; em[a] = 0; tag = "R4"; end
                else begin eer = 1; tag = "R9"; end
          3'd2: begin ers = int'(pcm_strap); tag = "R5"; end
          3'd3: begin eer = 1; tag = "R7"; end
          3'd4, 3'd5: begin
            ew = 1; edrop = !aok; ecoef = c[0]; echan = int'(a); eer = !aok;
            tag = aok ? "R6" : "R9"; etag = tag;
          end
          default: begin eer = 1; ew = 1; edrop = 1; tag = "R8"; etag = tag; end
        endcase
      end
    end
    clock_byte(b, 1'b0);
    chk_all(tag, eg, ecr, ers, eer, etx);
    if (etx == 1) begin
      chk("R6", int'(txn_coef), int'(ecoef));
      chk("R6", int'(txn_chan), echan);
      chk("R6", int'(txn_sub), int'(b));
    end
  endtask

  task automatic idle_chk();
    @(posedge clk); @(negedge clk);
    chk_all("R11", 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    em[0] = 0; em[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk_all("R2", 0, 0, 0, 0, 0);
    idle_chk();

    for (int s = 0; s < 2; s++) begin
      pcm_strap = s[0];
      for (int v = 0; v < 256; v++) begin
        feed(8'h60);
        feed(8'h51);
        feed(v[7:0]);
        if (ew) feed({1'b0, 3'b111, v[3], 3'b001});
        idle_chk();
      end
    end

    feed(8'hC1);
    feed(8'hA5);

    feed(8'h60);
    feed(8'hC0);
    frame_abort = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_abort = 1'b0;
    ew = 0;
    chk_all("R10", 0, 0, 0, 0, 0);
    feed(8'h70);
    chk("R10", int'(chan_mode[2:0]), 7);

    feed(8'hD1);
    clock_byte(8'h00, 1'b1);
    ew = 0;
    chk_all("R10", 0, 0, 0, 0, 0);
    feed(8'h51);
    chk("R10", int'(chan_mode[5:3]), 5);
    idle_chk();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule